// File: doc/BRIEF.md
# Log-Domain Mantissa Multiplier/Divider

This block multiplies or divides two normalized mantissas without a multiplier array. Each operand is an unsigned fraction `f` standing for the value `1 + f/2^W`, so it lies in [1.0, 2.0). Both operands address one lookup table with two read ports in the same cycle, which turns them into base-2 logarithms. One narrow adder then sums the two logarithms for a product, or takes their difference for a quotient. A second lookup table turns the combined logarithm back into a linear mantissa. Both tables are computed while the design elaborates, using integer fixed-point arithmetic, so no table is written out by hand.

The result is a mantissa in the same format and one exponent-adjust bit. In multiply mode the bit means the product is 2.0 or more, so the exponent must rise by one. In divide mode it means the quotient is below 1.0, so the exponent must fall by one. The unit is fully pipelined. It takes a new operand pair on every clock, and each result appears a fixed three cycles after its operands. It suits a floating-point datapath that keeps sign and exponent handling elsewhere.

Top module: `log_muldiv`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 from the clock edge after reset is asserted. Operations still in flight when reset is asserted produce no output.
- R2: An operand pair presented with `in_valid` = 1 before rising edge k produces its result with `out_valid` = 1 after rising edge k+2. The operand edge counts as the first of three, so the result is visible during the cycle that follows edge k+2.
- R3: The unit accepts a new operand pair on every clock. A run of back-to-back operations produces a run of back-to-back results in the same order.
- R4: With `in_div` = 0, the value (1 + `out_mant`/256) × 2^`out_exp_adj` lies within 2 output LSBs of the exact product (1 + a/256)(1 + b/256). Here one LSB is 2^`out_exp_adj`/256.
- R5: With `in_div` = 1, the value (1 + `out_mant`/256) × 2^(−`out_exp_adj`) lies within 2 output LSBs of the exact quotient (1 + a/256)/(1 + b/256). Here one LSB is 2^(−`out_exp_adj`)/256.
- R6: Two cases give exactly `out_mant` = 0 and `out_exp_adj` = 0: a divide of equal operands, and a multiply of two zero fields (1.0 × 1.0).
- R7: A cycle with `in_valid` = 0 produces no result: `out_valid` is 0 three edges later, unless another operation occupies that slot.
- R8: The operation select is carried with each operand pair. Multiplies and divides may alternate on every cycle, and each result follows its own operation.
- R9: A multiply of two all-ones fields (255 × 255 at W = 8) sets `out_exp_adj` to 1.
- R10: A divide whose dividend field is greater than or equal to its divisor field leaves `out_exp_adj` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_div | input | 1 | 0 = multiply a × b, 1 = divide a / b |
| in_a | input | W | Fraction of operand a (multiplicand or dividend) |
| in_b | input | W | Fraction of operand b (multiplier or divisor) |
| out_valid | output | 1 | Result present this cycle |
| out_mant | output | W | Fraction of the result mantissa |
| out_exp_adj | output | 1 | Exponent adjust: +1 for a multiply, −1 for a divide |

## Verification
A multiply and a divide can share the adder stage of the pipeline on the same cycle as neighbours: one is being summed while the other is being looked up. The bench provokes this by issuing every operand pair twice in adjacent cycles, first as a multiply and then as a divide. This sweeps all 65,536 pairs with the operation select toggling on every clock. Each result is judged against an exact real-number product or quotient, with a tolerance of 2 output LSBs at the exponent the design reports. The bench also checks that the result arrives exactly three edges after its operands, so that no result is attributed to its neighbour.

// File: rtl/log_muldiv.sv
module log_muldiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_div,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_mant,
  output logic         out_exp_adj
);
  localparam int N  = 1 << W;
  localparam int LW = W + 1;
  localparam int FB = 30;

  function automatic logic [63:0] isqrt(input logic [63:0] v);
    logic [63:0] rem, root, bv;
    rem = v; root = 64'd0; bv = 64'd1 << 62;
    for (int k = 0; k < 32; k++) begin
      if (rem >= root + bv) begin
        rem  = rem - (root + bv);
        root = (root >> 1) + bv;
      end else begin
        root = root >> 1;
      end
      bv = bv >> 2;
    end
    return root;
  endfunction

  function automatic logic [63:0] log_entry(input int idx);
    logic [63:0] x, r;
    x = (64'd1 << FB) + (64'(idx) << (FB - W));
    r = 64'd0;
    for (int k = 0; k < W + 4; k++) begin
      x = (x * x) >> FB;
      r = r << 1;
      if (x >= (64'd2 << FB)) begin
        x = x >> 1;
        r = r | 64'd1;
      end
    end
    return (r + 64'd8) >> 4;
  endfunction

  function automatic logic [63:0] alog_entry(input int idx);
    logic [63:0] y, m;
    y = 64'd1 << FB;
    for (int j = 0; j < W; j++) begin
      if (((idx >> j) & 1) == 1) y = y << 1;
      y = isqrt(y << FB);
    end
    m = (y - (64'd1 << FB) + (64'd1 << (FB - W - 1))) >> (FB - W);
    if (m > 64'(N - 1)) m = 64'(N - 1);
    return m;
  endfunction

  logic [LW-1:0] log_tab  [N];
  logic [W-1:0]  alog_tab [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_tab
    localparam logic [63:0] LV = log_entry(gi);
    localparam logic [63:0] AV = alog_entry(gi);
    assign log_tab[gi]  = LV[LW-1:0];
    assign alog_tab[gi] = AV[W-1:0];
  end

  logic [2:0]    vpipe;
  logic          s1_div;
  logic [LW-1:0] s1_la, s1_lb, s2_sum;
  logic [LW-1:0] comb;

  assign comb = s1_div ? s1_la - s1_lb : s1_la + s1_lb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[1:0], in_valid};

  always_ff @(posedge clk) begin
    s1_la       <= log_tab[in_a];
    s1_lb       <= log_tab[in_b];
    s1_div      <= in_div;
    s2_sum      <= comb;
    out_mant    <= alog_tab[s2_sum[W-1:0]];
    out_exp_adj <= s2_sum[W];
  end

  assign out_valid = vpipe[2];
endmodule

module log_muldiv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_div,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic [W-1:0] out_mant,
  input logic         out_exp_adj
);
  localparam logic [W-1:0] ALL1 = '1;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

  p_div_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_div && in_a == in_b) |-> ##3 (out_mant == '0 && !out_exp_adj));

  p_mul_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_div && in_a == '0 && in_b == '0) |-> ##3 (out_mant == '0 && !out_exp_adj));

  p_mul_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_div && in_a == ALL1 && in_b == ALL1) |-> ##3 out_exp_adj);

  p_div_noborrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_div && in_a >= in_b) |-> ##3 !out_exp_adj);
endmodule

bind log_muldiv log_muldiv_chk #(.W(W)) u_chk (.*);

// File: tb/test_log_muldiv.sv
module test_log_muldiv;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         dv;
    logic [31:0]  cyc;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_div;
  logic [W-1:0] in_a, in_b;
  logic out_valid, out_exp_adj;
  logic [W-1:0] out_mant;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;
  item_t q[$];

  log_muldiv #(.W(W)) i_log_muldiv (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic issue(input bit v, input logic [W-1:0] a, input logic [W-1:0] b, input bit dv);
    item_t it;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_div = dv;
    if (v) begin
      it.a = a; it.b = b; it.dv = dv; it.cyc = 32'(cyc);
      q.push_back(it);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (q.size() == 0) begin
        chk(0, $sformatf("R7: result with nothing issued, got valid=1 expected 0"));
      end else begin
        item_t it;
        real ea, eb, ex, sc, got, d;
        it = q.pop_front();
        chk(cyc == int'(it.cyc) + 3,
            $sformatf("R2/R3: result at cycle %0d expected %0d", cyc, it.cyc + 3));
        ea = 1.0 + real'(it.a) / 256.0;
        eb = 1.0 + real'(it.b) / 256.0;
        ex = it.dv ? ea / eb : ea * eb;
        sc = out_exp_adj ? (it.dv ? 0.5 : 2.0) : 1.0;
        got = (1.0 + real'(out_mant) / 256.0) * sc;
        d = (got - ex) * 256.0 / sc;
        if (d < 0.0) d = -d;
        if (it.dv)
          chk(d <= 2.0, $sformatf("R5/R8: %0d/%0d got mant=%0d adj=%0b err=%f lsb expected <=2",
                                  it.a, it.b, out_mant, out_exp_adj, d));
        else
          chk(d <= 2.0, $sformatf("R4/R8: %0d*%0d got mant=%0d adj=%0b err=%f lsb expected <=2",
                                  it.a, it.b, out_mant, out_exp_adj, d));
        if ((it.dv && it.a == it.b) || (!it.dv && it.a == 0 && it.b == 0))
          chk(out_mant == 0 && !out_exp_adj,
              $sformatf("R6: %0d,%0d div=%0b got mant=%0d adj=%0b expected 0 0",
                        it.a, it.b, it.dv, out_mant, out_exp_adj));
        if (!it.dv && it.a == 255 && it.b == 255)
          chk(out_exp_adj == 1'b1, $sformatf("R9: got adj=%0b expected 1", out_exp_adj));
        if (it.dv && it.a >= it.b)
          chk(out_exp_adj == 1'b0,
              $sformatf("R10: %0d/%0d got adj=%0b expected 0", it.a, it.b, out_exp_adj));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk)
    if (!done && cyc > 190000) begin
      done = 1;
      chk(0, "R2: watchdog expired, got hang expected completion");
      finish_run();
    end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_div = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, $sformatf("R1: got valid=%b in reset expected 0", out_valid));
    rst_n = 1'b1;

    // in-flight work discarded by reset
    issue(1, 8'd10, 8'd20, 0);
    issue(1, 8'd30, 8'd40, 1);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    q.delete();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, $sformatf("R1: got valid=%b after mid-run reset expected 0", out_valid));
    end
    rst_n = 1'b1;

    // sparse pattern with bubbles
    issue(1, 8'd0, 8'd0, 0);
    issue(0, 8'd1, 8'd1, 0);
    issue(0, 8'd1, 8'd1, 1);
    issue(1, 8'd255, 8'd255, 0);
    issue(0, 8'd0, 8'd0, 0);
    issue(1, 8'd0, 8'd128, 1);
    issue(1, 8'd77, 8'd77, 1);
    for (int k = 0; k < 5; k++) begin
      issue(0, 8'd0, 8'd0, 0);
      if (q.size() == 0)
        chk(out_valid === 1'b0, $sformatf("R7: got valid=%b after bubbles expected 0", out_valid));
    end

    // exhaustive sweep, op select toggling every cycle
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        issue(1, 8'(a), 8'(b), 0);
        issue(1, 8'(a), 8'(b), 1);
      end
    for (int k = 0; k < 5; k++) issue(0, 8'd0, 8'd0, 0);
    chk(q.size() == 0, $sformatf("R3: got %0d results missing expected 0", q.size()));
    chk(out_valid === 1'b0, $sformatf("R7: got valid=%b when idle expected 0", out_valid));
    done = 1;
    finish_run();
  end
endmodule